// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block runs through a table of conversion command words for an analog-to-digital converter. Each command word holds a channel number, an end-of-queue marker and a pause marker. The block reads the entry under its live command pointer and launches a conversion of that channel. When the conversion ends, it writes the result to the result slot whose index matches the command. Software arms a scan by pulsing `arm`. The scan then runs in one of two modes. In external trigger mode, a rising trigger edge starts the scan, and a paused entry holds the scan until the next edge. In gated single-scan mode, the scan runs while a gate input is high and starts again from entry 0 each time the gate reopens.

The block keeps two pointers. The live pointer `cwp` is also the read address into the command table. The completed pointer `cwpq` moves only when a result is written, so it trails the live pointer. A 4-bit status code reports whether the queue is off, running or paused. When the scan ends, a sticky completion flag sets and the enable bit clears. A fixed-latency stub inside the block stands in for the converter and returns `(channel*37+11) mod 2^RES_W`.

Top module: `adcq_seq`

## Requirements
- R1: After reset, `qs`=0, `cf`=0, `sse`=0, `cwp`=0, `cwpq`=0 and `res_we`=0.
- R2: `qs` is 0 whenever `sse` is clear, 4 while the queue is paused, and 8 at every other time the queue is enabled.
- R3: Each conversion lasts CONV_CYC (at least 14) clocks, plus one launch cycle. During an uninterrupted scan, result writes therefore come exactly CONV_CYC+1 cycles apart.
- R4: The result for the command in slot n is written with `res_addr`=n. Its data is `(ch*37+11) mod 2^RES_W`, where ch is bits [CHAN_W-1:0] of that command word.
- R5: In trigger mode, when the finished command has its pause bit (bit CHAN_W+1) clear and does not end the scan, `cwp` advances by one in the same cycle that the result write appears.
- R6: In trigger mode, when the finished command has its pause bit set, `cwp` holds and `qs` shows 4. On the next trigger rising edge, `cwp` advances by one and the queue resumes.
- R7: `cwpq` changes only together with a result write and then equals `res_addr`. At scan completion it equals `cwp`.
- R8: A command with its end-of-queue bit (bit CHAN_W) set ends the scan, and so does the command in slot DEPTH-1. In that cycle `cf` sets and `sse` clears together.
- R9: In trigger mode, trigger edges have no effect while a conversion runs, while paused entries wait with the trigger held high, or while `sse` is clear. Only a rising edge acts.
- R10: In gated mode, conversions run back to back while the gate is open, and pause bits are ignored. If the gate closes during a conversion, that conversion completes and its result is written. The queue then waits with `cwp`=0, and reopening the gate restarts from slot 0.
- R11: `cf` clears on a one written to `cf_clr`. An `arm` pulse while the queue is off sets `sse` and returns `cwp` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_gated | input | 1 | 0 = external trigger mode, 1 = gated single-scan mode |
| trig_in | input | 1 | Asynchronous trigger, acted on at its rising edge |
| gate_in | input | 1 | Asynchronous gate level |
| arm | input | 1 | Pulse that sets the single-scan enable |
| cf_clr | input | 1 | Write-one-to-clear for the completion flag |
| ccw_word | input | CHAN_W+2 | Command word at slot `cwp`: {pause, eoq, channel} |
| cwp | output | IDX_W | Live command pointer, also the table read address |
| cwpq | output | IDX_W | Index of the last written result |
| qs | output | 4 | Queue status: 0 off, 8 active, 4 paused |
| cf | output | 1 | Completion flag |
| sse | output | 1 | Single-scan enable |
| res_we | output | 1 | Result write strobe |
| res_addr | output | IDX_W | Result slot index |
| res_data | output | RES_W | Conversion result |

## Verification
The assertions assume that `mode_gated` stays constant while `sse` is set. They also assume that `ccw_word` is a purely combinational lookup of `cwp`, and that `arm` is only pulsed while the queue is off. The bench changes mode only between scans, with the queue idle. It models the command table as a combinational array indexed by `cwp`, and it arms only after it has seen `cf` set. Triggers and gate changes are driven asynchronously to the sequencer's state. Because the bench drives them only at points where the expected outcome does not depend on the exact synchroniser cycle, it checks outcomes (pointer values, write counts, write order) instead of the cycle in which a trigger lands.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_LAUNCH,
      ST_CONV,
      ST_PAUSE
   } adcq_state_e;

   localparam logic [3:0] QS_OFF  = 4'd0;
   localparam logic [3:0] QS_RUN  = 4'd8;
   localparam logic [3:0] QS_HOLD = 4'd4;
endpackage

// File: rtl/adcq_sync.sv
module adcq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adcq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adcq_conv_stub.sv
module adcq_conv_stub #(
   parameter int CONV_CYC = 14,
   parameter int CHAN_W   = 6,
   parameter int RES_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CHAN_W-1:0] chan,
   output logic              eoc,
   output logic [RES_W-1:0]  data
);
   localparam int CNT_W = $clog2(CONV_CYC + 1);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CHAN_W-1:0] chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         chan_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(CONV_CYC - 1);
         chan_q <= chan;
      end else if (busy_q && cnt_q == '0) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign eoc  = busy_q && (cnt_q == '0);
   assign data = RES_W'(32'(chan_q) * 32'd37 + 32'd11);

   // independent cycle counter for the conversion window
   logic [CNT_W-1:0] win_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      win_q <= '0;
      else if (start)  win_q <= '0;
      else if (busy_q) win_q <= win_q + CNT_W'(1);
   end

   assert_conv_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> (win_q == CNT_W'(CONV_CYC - 1)));
   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!busy_q || eoc));
endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
   import adcq_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int CHAN_W = 6,
   parameter int RES_W  = 10,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CCW_W = CHAN_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_gated,
   input  logic              trig_edge,
   input  logic              gate_lvl,
   input  logic              arm,
   input  logic              cf_clr,
   input  logic [CCW_W-1:0]  ccw_word,
   input  logic              eoc,
   input  logic [RES_W-1:0]  conv_data,
   output logic              start,
   output logic [CHAN_W-1:0] start_chan,
   output logic [IDX_W-1:0]  cwp,
   output logic [IDX_W-1:0]  cwpq,
   output logic [3:0]        qs,
   output logic              cf,
   output logic              sse,
   output logic              res_we,
   output logic [IDX_W-1:0]  res_addr,
   output logic [RES_W-1:0]  res_data
);
   localparam int PAUSE_BIT = CHAN_W + 1;
   localparam int EOQ_BIT   = CHAN_W;

   adcq_state_e      state_q;
   logic [IDX_W-1:0] cwp_q, cwpq_q, raddr_q;
   logic [RES_W-1:0] rdata_q;
   logic             rwe_q, sse_q, cf_q;
   logic             cur_pause_q, cur_eoq_q;
   logic             scan_last, cf_set, go;

   assign scan_last  = cur_eoq_q || (cwp_q == IDX_W'(DEPTH - 1));
   assign cf_set     = (state_q == ST_CONV) && eoc && scan_last;
   assign go         = mode_gated ? gate_lvl : trig_edge;
   assign start      = (state_q == ST_LAUNCH);
   assign start_chan = ccw_word[CHAN_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cwp_q       <= '0;
         cwpq_q      <= '0;
         raddr_q     <= '0;
         rdata_q     <= '0;
         rwe_q       <= 1'b0;
         sse_q       <= 1'b0;
         cur_pause_q <= 1'b0;
         cur_eoq_q   <= 1'b0;
      end else begin
         rwe_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (arm) begin
                  sse_q   <= 1'b1;
                  cwp_q   <= '0;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (go) state_q <= ST_LAUNCH;
            end
            ST_LAUNCH: begin
               cur_pause_q <= ccw_word[PAUSE_BIT];
               cur_eoq_q   <= ccw_word[EOQ_BIT];
               state_q     <= ST_CONV;
            end
            ST_CONV: begin
               if (eoc) begin
                  rwe_q   <= 1'b1;
                  raddr_q <= cwp_q;
                  rdata_q <= conv_data;
                  cwpq_q  <= cwp_q;
                  if (scan_last) begin
                     sse_q   <= 1'b0;
                     state_q <= ST_IDLE;
                  end else if (mode_gated) begin
                     if (gate_lvl) begin
                        cwp_q   <= cwp_q + IDX_W'(1);
                        state_q <= ST_LAUNCH;
                     end else begin
                        cwp_q   <= '0;
                        state_q <= ST_WAIT;
                     end
                  end else if (cur_pause_q) begin
                     state_q <= ST_PAUSE;
                  end else begin
                     cwp_q   <= cwp_q + IDX_W'(1);
                     state_q <= ST_LAUNCH;
                  end
               end
            end
            ST_PAUSE: begin
               if (trig_edge) begin
                  cwp_q   <= cwp_q + IDX_W'(1);
                  state_q <= ST_LAUNCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cf_q <= 1'b0;
      else if (cf_set) cf_q <= 1'b1;
      else if (cf_clr) cf_q <= 1'b0;
   end

   assign qs       = !sse_q ? QS_OFF : (state_q == ST_PAUSE) ? QS_HOLD : QS_RUN;
   assign cwp      = cwp_q;
   assign cwpq     = cwpq_q;
   assign cf       = cf_q;
   assign sse      = sse_q;
   assign res_we   = rwe_q;
   assign res_addr = raddr_q;
   assign res_data = rdata_q;

   assert_qs_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (qs == QS_OFF) || (qs == QS_RUN) || (qs == QS_HOLD));
   assert_qs_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sse |-> (qs == QS_OFF));
   assert_write_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |=> !res_we);
   assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((qs == QS_HOLD) && !trig_edge) |=> $stable(cwp));
   assert_cwpq_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cwpq) |-> res_we);
   assert_done_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cf) |-> $fell(sse));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sse |=> !res_we);
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq #(
   parameter int DEPTH       = 64,
   parameter int CHAN_W      = 6,
   parameter int RES_W       = 10,
   parameter int CONV_CYC    = 14,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CCW_W = CHAN_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_gated,
   input  logic             trig_in,
   input  logic             gate_in,
   input  logic             arm,
   input  logic             cf_clr,
   input  logic [CCW_W-1:0] ccw_word,
   output logic [IDX_W-1:0] cwp,
   output logic [IDX_W-1:0] cwpq,
   output logic [3:0]       qs,
   output logic             cf,
   output logic             sse,
   output logic             res_we,
   output logic [IDX_W-1:0] res_addr,
   output logic [RES_W-1:0] res_data
);
   generate
      if (CONV_CYC < 14) begin : g_bad_conv
         $error("adcq_seq: CONV_CYC must be at least 14");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("adcq_seq: DEPTH must be at least 2");
      end
      if (RES_W < 1 || RES_W > 32) begin : g_bad_res
         $error("adcq_seq: RES_W must be 1..32");
      end
      if (CHAN_W < 1) begin : g_bad_chan
         $error("adcq_seq: CHAN_W must be at least 1");
      end
   endgenerate

   logic trig_s, trig_d_q, gate_s, trig_edge;
   logic start, eoc;
   logic [CHAN_W-1:0] start_chan;
   logic [RES_W-1:0]  conv_data;

   adcq_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s));
   adcq_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_d_q <= 1'b0;
      else        trig_d_q <= trig_s;
   end
   assign trig_edge = trig_s && !trig_d_q;

   adcq_ctrl #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .RES_W(RES_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_gated(mode_gated),
      .trig_edge(trig_edge), .gate_lvl(gate_s), .arm(arm), .cf_clr(cf_clr),
      .ccw_word(ccw_word), .eoc(eoc), .conv_data(conv_data),
      .start(start), .start_chan(start_chan), .cwp(cwp), .cwpq(cwpq),
      .qs(qs), .cf(cf), .sse(sse), .res_we(res_we), .res_addr(res_addr),
      .res_data(res_data));

   adcq_conv_stub #(.CONV_CYC(CONV_CYC), .CHAN_W(CHAN_W), .RES_W(RES_W)) u_conv (
      .clk(clk), .rst_n(rst_n), .start(start), .chan(start_chan),
      .eoc(eoc), .data(conv_data));
endmodule

// File: tb/sim_adcq_seq.sv
module sim_adcq_seq;
   localparam int DEPTH = 8, CHAN_W = 6, RES_W = 10, CONV_CYC = 14;
   localparam int IDX_W = 3, CCW_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_gated = 1'b0, trig_in = 1'b0, gate_in = 1'b0, arm = 1'b0, cf_clr = 1'b0;
   logic [CCW_W-1:0] ccw_word;
   logic [IDX_W-1:0] cwp, cwpq, res_addr;
   logic [3:0]       qs;
   logic             cf, sse, res_we;
   logic [RES_W-1:0] res_data;

   logic [CCW_W-1:0] tab [DEPTH];
   int n_chk = 0, n_err = 0, cyc = 0, wr_cnt = 0, prev_wr = -1;
   int wlog [64];
   bit gap_en = 0, cf_prev = 0, sse_prev = 0;

   always #10 clk = ~clk;
   assign ccw_word = tab[cwp];

   adcq_seq #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .RES_W(RES_W), .CONV_CYC(CONV_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_gated(mode_gated), .trig_in(trig_in),
      .gate_in(gate_in), .arm(arm), .cf_clr(cf_clr), .ccw_word(ccw_word),
      .cwp(cwp), .cwpq(cwpq), .qs(qs), .cf(cf), .sse(sse), .res_we(res_we),
      .res_addr(res_addr), .res_data(res_data));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input int a);
      return ((int'(tab[a][5:0]) * 37) + 11) % 1024;
   endfunction

   // monitor at the falling edge, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n && res_we) begin
         chk(int'(res_data) == model(int'(res_addr)), "R4 data", int'(res_data), model(int'(res_addr)));
         chk(cwpq == res_addr, "R7 cwpq", int'(cwpq), int'(res_addr));
         if (!mode_gated && !tab[res_addr][7] && !tab[res_addr][6] && res_addr != 3'd7)
            chk(int'(cwp) == int'(res_addr) + 1, "R5 advance", int'(cwp), int'(res_addr) + 1);
         if (gap_en && prev_wr >= 0)
            chk(cyc - prev_wr == CONV_CYC + 1, "R3 spacing", cyc - prev_wr, CONV_CYC + 1);
         prev_wr = cyc;
         if (wr_cnt < 64) wlog[wr_cnt] = int'(res_addr);
         wr_cnt++;
      end
      if (rst_n && cf && !cf_prev)
         chk(!sse && sse_prev, "R8 cf/sse same cycle", int'(sse), 0);
      cf_prev = cf;
      sse_prev = sse;
   end

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic pulse_trig();
      trig_in = 1'b1; step(3); trig_in = 1'b0; step(1);
   endtask

   task automatic do_arm();
      arm = 1'b1; step(1); arm = 1'b0; step(1);
   endtask

   task automatic wait_cf(input int lim, input string req);
      int k = 0;
      while (!cf && k < lim) begin step(1); k++; end
      chk(cf == 1'b1, req, int'(cf), 1);
   endtask

   task automatic wait_wr(input int n, input int lim);
      int k = 0;
      while (wr_cnt < n && k < lim) begin step(1); k++; end
      chk(wr_cnt >= n, "R4 write arrives", wr_cnt, n);
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) tab[i] = '0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk(qs == 4'd0 && cf == 1'b0 && sse == 1'b0, "R1 flags", int'(qs), 0);
      chk(cwp == '0 && cwpq == '0 && res_we == 1'b0, "R1 pointers", int'(cwp), 0);

      // trigger mode, no pauses, eoq at slot 3
      tab[0] = 8'd5; tab[1] = 8'd17; tab[2] = 8'd42; tab[3] = 8'h40 | 8'd63;
      mode_gated = 1'b0;
      do_arm();
      chk(sse == 1'b1 && qs == 4'd8, "R2 armed status", int'(qs), 8);
      chk(cwp == '0, "R11 arm pointer", int'(cwp), 0);
      wr_cnt = 0; prev_wr = -1; gap_en = 1;
      pulse_trig();
      wait_cf(200, "R8 eoq completion");
      step(2);
      gap_en = 0;
      chk(wr_cnt == 4, "R8 eoq write count", wr_cnt, 4);
      for (int i = 0; i < 4; i++) chk(wlog[i] == i, "R4 slot order", wlog[i], i);
      chk(cwp == 3'd3 && cwpq == 3'd3, "R7 pointers meet", int'(cwpq), int'(cwp));
      chk(qs == 4'd0 && sse == 1'b0, "R2 off after scan", int'(qs), 0);

      // R11 write-one-to-clear
      cf_clr = 1'b1; step(1); cf_clr = 1'b0; step(1);
      chk(cf == 1'b0, "R11 cf cleared", int'(cf), 0);

      // trigger mode with pause bits
      tab[0] = 8'h80 | 8'd9; tab[1] = 8'd20; tab[2] = 8'h80 | 8'd33; tab[3] = 8'h40 | 8'd50;
      do_arm();
      chk(cwp == '0 && sse == 1'b1, "R11 re-arm from 0", int'(cwp), 0);
      wr_cnt = 0;
      pulse_trig();
      step(8);
      pulse_trig();              // lands during conversion of slot 0
      wait_wr(1, 100);
      step(40);
      chk(qs == 4'd4, "R6 paused status", int'(qs), 4);
      chk(cwp == '0, "R6 pointer held", int'(cwp), 0);
      chk(wr_cnt == 1, "R9 trigger during conversion ignored", wr_cnt, 1);
      trig_in = 1'b1;            // resume and hold high
      step(8);
      chk(cwp == 3'd1, "R6 advance on trigger", int'(cwp), 1);
      step(60);
      chk(qs == 4'd4 && cwp == 3'd2, "R9 held trigger no retrigger", int'(cwp), 2);
      chk(wr_cnt == 3, "R9 held trigger write count", wr_cnt, 3);
      trig_in = 1'b0; step(3);
      pulse_trig();
      wait_cf(200, "R8 completion after pauses");
      step(2);
      chk(wr_cnt == 4 && cwp == 3'd3, "R6 final pointer", int'(cwp), 3);
      cf_clr = 1'b1; step(1); cf_clr = 1'b0; step(1);

      // trigger while disarmed
      wr_cnt = 0;
      pulse_trig();
      step(40);
      chk(wr_cnt == 0 && qs == 4'd0, "R9 disarmed trigger ignored", wr_cnt, 0);

      // gated single-scan, no eoq, pause on slot 4 (ignored)
      for (int i = 0; i < DEPTH; i++) tab[i] = 8'(3 + 7 * i);
      tab[4] = tab[4] | 8'h80;
      mode_gated = 1'b1;
      do_arm();
      wr_cnt = 0;
      gate_in = 1'b1;
      wait_wr(2, 200);
      gate_in = 1'b0;            // closes while slot 2 converts
      step(50);
      chk(wr_cnt == 3, "R10 in-flight conversion completes", wr_cnt, 3);
      chk(wlog[2] == 2, "R10 last slot before close", wlog[2], 2);
      chk(cwp == '0 && sse == 1'b1 && qs == 4'd8, "R10 waiting at slot 0", int'(cwp), 0);
      gate_in = 1'b1;
      wait_cf(400, "R8 last-slot completion");
      step(2);
      gate_in = 1'b0;
      chk(wlog[3] == 0, "R10 restart from slot 0", wlog[3], 0);
      chk(wr_cnt == 11, "R10 pause ignored, full scan", wr_cnt, 11);
      chk(wlog[10] == 7 && cwp == 3'd7, "R8 ends at slot DEPTH-1", int'(cwp), 7);
      chk(sse == 1'b0 && qs == 4'd0, "R8 sse cleared", int'(sse), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule